// File: doc/BRIEF.md
# Monochrome Hardware Cursor Overlay

This block draws a 64 by 64 two-plane monochrome cursor over a stream of 32-bit display pixels. Before each scanline, a line-start pulse carries the index of the coming line. If the cursor covers that line, the block reads the line's 16 bitmap bytes from cursor memory, one byte per cycle, into a local row buffer. During active video it reads no memory at all. Each pixel then passes through a fixed two-stage pipeline. Where a pixel lies under the cursor, the pipeline replaces it according to the AND and XOR bits of its column. All other pixels pass through unchanged.

The cursor position and its two 24-bit colours come from shadow registers. These registers follow their inputs only while the lock input is low, so software can update all of them together without the display showing a partly changed cursor. The active line width is the horizontal display field plus one, times eight. A cursor that reaches this width is cut off at the right edge and does not wrap onto the next line.

Top module: `cursor_overlay`

## Requirements
- R1: On a line-start pulse for a covered line, the block asserts `bm_rd` for exactly 16 consecutive cycles. The addresses it issues are row*16+0 through row*16+15, where row = line_y - cursor y. Read data is expected on `bm_data` one cycle after each read.
- R2: In each row, bytes 0 to 7 hold the AND plane and bytes 8 to 15 hold the XOR plane. Byte k covers columns 8k to 8k+7, and bit 7 of the byte is the leftmost of those columns.
- R3: For a covered pixel whose AND bit and XOR bit are both 1, the output is the bitwise complement of the input pixel.
- R4: For a covered pixel whose AND bit is 1 and XOR bit is 0, the output equals the input pixel.
- R5: For a covered pixel whose AND bit is 0, the output is {colour1, 8'hFF} if the XOR bit is 1, and {colour0, 8'hFF} otherwise.
- R6: A line is covered only when all of these hold: the enable is high, cursor y <= line_y < cursor y + 64, and line_y <= `v_end`. On any other line the block issues no read, and every pixel of the line passes through unchanged.
- R7: Within a covered line, a pixel is modified only when cursor x <= pix_x < cursor x + 64 and pix_x < (h_disp+1)*8. Every other pixel passes through unchanged, so the cursor is clipped at the right edge.
- R8: While `cur_lock` is high, the position and colours in use keep their previous values, even if their inputs change.
- R9: `out_valid` and `pix_out` follow `pix_valid` and `pix_in` by exactly two clock cycles. After reset, `out_valid` and `bm_rd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_en | input | 1 | Cursor enable, sampled at line start |
| cur_lock | input | 1 | Holds the shadowed position and colours while high |
| cur_x_in | input | XW | Cursor left column |
| cur_y_in | input | XW | Cursor top line |
| cur_c0_in | input | 24 | Colour for AND=0, XOR=0 |
| cur_c1_in | input | 24 | Colour for AND=0, XOR=1 |
| h_disp | input | HD_W | Horizontal display field; width = (h_disp+1)*8 |
| v_end | input | XW | Last displayed line index |
| line_start | input | 1 | One-cycle pulse before a scanline |
| line_y | input | XW | Index of the coming scanline |
| bm_rd | output | 1 | Bitmap byte read strobe |
| bm_addr | output | 10 | Bitmap byte address |
| bm_data | input | 8 | Bitmap byte, one cycle after the read |
| pix_valid | input | 1 | Input pixel valid |
| pix_x | input | XW | Input pixel column |
| pix_in | input | 32 | Input pixel |
| out_valid | output | 1 | Output pixel valid |
| pix_out | output | 32 | Output pixel |

## Verification
Each pixel result is due two cycles after the pixel is driven. The bench holds its expected values in a two-deep expected pipeline that advances on every falling edge. It compares `out_valid` and `pix_out` against the entry driven two edges earlier, including in cycles with bubbles. Bitmap reads start in the cycle after the line-start pulse is sampled. The bench checks each read address as it appears and counts the reads for each line. It starts driving pixels only after the 16-cycle row fetch and its one-cycle data return have completed. Changes to the shadowed inputs are followed by idle cycles, so that the bench model updates at the same edge as the registers.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
    localparam int CUR_SIZE    = 64;
    localparam int PLANE_BYTES = CUR_SIZE / 8;
    localparam int ROW_BYTES   = 2 * PLANE_BYTES;
    localparam int ROW_W       = $clog2(CUR_SIZE);
    localparam int BYTE_W      = $clog2(ROW_BYTES);
    localparam int ADDR_W      = ROW_W + BYTE_W;
    localparam int PIX_W       = 32;
    localparam int CLR_W       = 24;

    typedef enum logic [1:0] {
        MIX_COLOR0,
        MIX_COLOR1,
        MIX_PASS,
        MIX_INVERT
    } cur_mix_e;

    typedef struct packed {
        logic             valid;
        logic             hit;
        logic             and_b;
        logic             xor_b;
        logic [PIX_W-1:0] pix;
    } cur_stage_t;

    function automatic cur_mix_e mix_decode(input logic and_b, input logic xor_b);
        if (and_b) return xor_b ? MIX_INVERT : MIX_PASS;
        return xor_b ? MIX_COLOR1 : MIX_COLOR0;
    endfunction

    function automatic logic [PIX_W-1:0] apply_mix(input cur_mix_e m,
                                                   input logic [PIX_W-1:0] pix,
                                                   input logic [CLR_W-1:0] c0,
                                                   input logic [CLR_W-1:0] c1);
        case (m)
            MIX_INVERT: return ~pix;
            MIX_PASS:   return pix;
            MIX_COLOR1: return {c1, 8'hFF};
            default:    return {c0, 8'hFF};
        endcase
    endfunction
endpackage

// File: rtl/cursor_row_fetch.sv
module cursor_row_fetch
    import cursor_pkg::*;
#(
    parameter int XW = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cur_en,
    input  logic [XW-1:0]     ypos,
    input  logic [XW-1:0]     v_end,
    input  logic              line_start,
    input  logic [XW-1:0]     line_y,
    output logic              bm_rd,
    output logic [ADDR_W-1:0] bm_addr,
    input  logic [7:0]        bm_data,
    output logic              line_hit,
    output logic [CUR_SIZE-1:0] and_pl,
    output logic [CUR_SIZE-1:0] xor_pl
);
    logic [XW:0]       dy;
    logic              row_hit;
    logic              busy;
    logic [BYTE_W-1:0] cnt;
    logic [ROW_W-1:0]  row_q;
    logic              rd_q;
    logic [BYTE_W-1:0] idx_q;

    assign dy      = {1'b0, line_y} - {1'b0, ypos};
    assign row_hit = cur_en && !dy[XW] && (dy[XW-1:0] < XW'(CUR_SIZE)) && (line_y <= v_end);

    assign bm_rd   = busy;
    assign bm_addr = {row_q, cnt};

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cnt      <= '0;
            row_q    <= '0;
            rd_q     <= 1'b0;
            idx_q    <= '0;
            line_hit <= 1'b0;
            and_pl   <= '0;
            xor_pl   <= '0;
        end else begin
            if (line_start) begin
                line_hit <= row_hit;
                busy     <= row_hit;
                cnt      <= '0;
                row_q    <= dy[ROW_W-1:0];
            end else if (busy) begin
                cnt <= cnt + 1'b1;
                if (cnt == BYTE_W'(ROW_BYTES - 1)) busy <= 1'b0;
            end
            rd_q  <= bm_rd;
            idx_q <= cnt;
            if (rd_q) begin
                for (int j = 0; j < 8; j++) begin
                    if (idx_q[BYTE_W-1])
                        xor_pl[{idx_q[BYTE_W-2:0], 3'(j)}] <= bm_data[7-j];
                    else
                        and_pl[{idx_q[BYTE_W-2:0], 3'(j)}] <= bm_data[7-j];
                end
            end
        end
    end

    AST_NO_FETCH_ON_MISS: assert property (@(posedge clk) disable iff (rst)
        line_start && !row_hit |=> !bm_rd); // R6
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        bm_rd && $past(bm_rd) && !$past(line_start) |-> bm_addr == $past(bm_addr) + 1'b1); // R1
endmodule

// File: rtl/cursor_pix_pipe.sv
module cursor_pix_pipe
    import cursor_pkg::*;
#(
    parameter int XW = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pix_valid,
    input  logic [XW-1:0]       pix_x,
    input  logic [PIX_W-1:0]    pix_in,
    input  logic [XW-1:0]       xpos,
    input  logic [XW:0]         act_w,
    input  logic                line_hit,
    input  logic [CUR_SIZE-1:0] and_pl,
    input  logic [CUR_SIZE-1:0] xor_pl,
    input  logic [CLR_W-1:0]    c0,
    input  logic [CLR_W-1:0]    c1,
    output logic                out_valid,
    output logic [PIX_W-1:0]    pix_out
);
    logic [XW:0]      dx;
    logic             col_hit;
    logic [ROW_W-1:0] col;
    cur_stage_t       s1;

    assign dx      = {1'b0, pix_x} - {1'b0, xpos};
    assign col     = dx[ROW_W-1:0];
    assign col_hit = line_hit && !dx[XW] && (dx[XW-1:0] < XW'(CUR_SIZE))
                     && ({1'b0, pix_x} < act_w);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1        <= '0;
            out_valid <= 1'b0;
            pix_out   <= '0;
        end else begin
            s1.valid  <= pix_valid;
            s1.hit    <= col_hit;
            s1.and_b  <= and_pl[col];
            s1.xor_b  <= xor_pl[col];
            s1.pix    <= pix_in;
            out_valid <= s1.valid;
            pix_out   <= s1.hit ? apply_mix(mix_decode(s1.and_b, s1.xor_b), s1.pix, c0, c1)
                                : s1.pix;
        end
    end

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(pix_valid, 2)); // R9
    AST_CLIP_PASS: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(pix_valid && ({1'b0, pix_x} >= act_w), 2) |-> pix_out == $past(pix_in, 2)); // R7
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int XW   = 12,
    parameter int HD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cur_en,
    input  logic              cur_lock,
    input  logic [XW-1:0]     cur_x_in,
    input  logic [XW-1:0]     cur_y_in,
    input  logic [CLR_W-1:0]  cur_c0_in,
    input  logic [CLR_W-1:0]  cur_c1_in,
    input  logic [HD_W-1:0]   h_disp,
    input  logic [XW-1:0]     v_end,
    input  logic              line_start,
    input  logic [XW-1:0]     line_y,
    output logic              bm_rd,
    output logic [ADDR_W-1:0] bm_addr,
    input  logic [7:0]        bm_data,
    input  logic              pix_valid,
    input  logic [XW-1:0]     pix_x,
    input  logic [PIX_W-1:0]  pix_in,
    output logic              out_valid,
    output logic [PIX_W-1:0]  pix_out
);
    logic [XW-1:0]       x_sh, y_sh;
    logic [CLR_W-1:0]    c0_sh, c1_sh;
    logic [XW:0]         act_w;
    logic                line_hit;
    logic [CUR_SIZE-1:0] and_pl, xor_pl;

    assign act_w = ((XW+1)'(h_disp) + (XW+1)'(1)) << 3;

    always_ff @(posedge clk) begin
        if (rst) begin
            x_sh  <= '0;
            y_sh  <= '0;
            c0_sh <= '0;
            c1_sh <= '0;
        end else if (!cur_lock) begin
            x_sh  <= cur_x_in;
            y_sh  <= cur_y_in;
            c0_sh <= cur_c0_in;
            c1_sh <= cur_c1_in;
        end
    end

    cursor_row_fetch #(.XW(XW)) u_fetch (
        .clk(clk), .rst(rst), .cur_en(cur_en), .ypos(y_sh), .v_end(v_end),
        .line_start(line_start), .line_y(line_y), .bm_rd(bm_rd), .bm_addr(bm_addr),
        .bm_data(bm_data), .line_hit(line_hit), .and_pl(and_pl), .xor_pl(xor_pl)
    );

    cursor_pix_pipe #(.XW(XW)) u_pix (
        .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_x(pix_x), .pix_in(pix_in),
        .xpos(x_sh), .act_w(act_w), .line_hit(line_hit), .and_pl(and_pl),
        .xor_pl(xor_pl), .c0(c0_sh), .c1(c1_sh), .out_valid(out_valid), .pix_out(pix_out)
    );

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
        $past(cur_lock) |-> $stable(x_sh) && $stable(y_sh) && $stable(c0_sh) && $stable(c1_sh)); // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !out_valid && !bm_rd); // R9
endmodule

// File: tb/cursor_overlay_bench.sv
module cursor_overlay_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cur_en = 1'b0, cur_lock = 1'b0;
    logic [11:0] cur_x_in = '0, cur_y_in = '0;
    logic [23:0] cur_c0_in = '0, cur_c1_in = '0;
    logic [7:0]  h_disp = '0;
    logic [11:0] v_end = '0;
    logic        line_start = 1'b0;
    logic [11:0] line_y = '0;
    logic        bm_rd;
    logic [9:0]  bm_addr;
    logic [7:0]  bm_data = '0;
    logic        pix_valid = 1'b0;
    logic [11:0] pix_x = '0;
    logic [31:0] pix_in = '0;
    logic        out_valid;
    logic [31:0] pix_out;

    cursor_overlay u_cursor_overlay (
        .clk(clk), .rst(rst), .cur_en(cur_en), .cur_lock(cur_lock),
        .cur_x_in(cur_x_in), .cur_y_in(cur_y_in), .cur_c0_in(cur_c0_in),
        .cur_c1_in(cur_c1_in), .h_disp(h_disp), .v_end(v_end),
        .line_start(line_start), .line_y(line_y), .bm_rd(bm_rd), .bm_addr(bm_addr),
        .bm_data(bm_data), .pix_valid(pix_valid), .pix_x(pix_x), .pix_in(pix_in),
        .out_valid(out_valid), .pix_out(pix_out)
    );

    always #5 clk = ~clk;

    logic [7:0] bmem [1024];
    always @(posedge clk) if (bm_rd) bm_data <= bmem[bm_addr];

    int checks = 0, fails = 0;
    bit done = 0;
    int e_x = 0, e_y = 0, e_w = 8, e_row = 0, rd_k = 0;
    logic [23:0] e_c0 = '0, e_c1 = '0;
    bit e_lhit = 0;
    bit d1_v = 0, d2_v = 0;
    logic [31:0] d1_p = '0, d2_p = '0;
    string d1_t = "", d2_t = "";

    function automatic logic [31:0] exp_pix(input int x, input logic [31:0] p, output string tag);
        int col, a;
        logic ab, xb;
        if (!e_lhit) begin tag = "R6"; return p; end
        if (x < e_x || x >= e_x + 64 || x >= e_w) begin tag = "R7"; return p; end
        col = x - e_x;
        a = e_row * 16 + col / 8;
        ab = bmem[a][7 - col % 8];
        xb = bmem[a + 8][7 - col % 8];
        if (ab && xb) begin tag = "R3 (R2 layout)"; return ~p; end
        if (ab) begin tag = "R4 (R2 layout)"; return p; end
        tag = "R5 (R2 layout)";
        return {(xb ? e_c1 : e_c0), 8'hFF};
    endfunction

    task automatic tick(input logic ls, input logic vld, input int x, input logic [31:0] p);
        string t;
        logic [31:0] ev;
        @(negedge clk);
        if (out_valid || d2_v) begin
            checks++;
            if (out_valid !== d2_v) begin
                fails++;
                $display("FAIL R9 out_valid got %b exp %b", out_valid, d2_v);
            end else if (pix_out !== d2_p) begin
                fails++;
                $display("FAIL %s pix_out got %h exp %h", d2_t, pix_out, d2_p);
            end
        end
        if (bm_rd) begin
            checks++;
            if (!e_lhit || rd_k >= 16 || bm_addr !== 10'(e_row * 16 + rd_k)) begin
                fails++;
                $display("FAIL R1 bm_addr got %0d exp %0d", bm_addr, e_row * 16 + rd_k);
            end
            rd_k++;
        end
        d2_v = d1_v; d2_p = d1_p; d2_t = d1_t;
        ev = exp_pix(x, p, t);
        d1_v = vld; d1_p = ev; d1_t = t;
        line_start = ls;
        pix_valid = vld;
        pix_x = 12'(x);
        pix_in = p;
    endtask

    task automatic set_cfg(input bit en, input bit lk, input int x, input int y,
                           input logic [23:0] c0, input logic [23:0] c1,
                           input int hd, input int ve);
        cur_en = en; cur_lock = lk; h_disp = 8'(hd); v_end = 12'(ve);
        cur_x_in = 12'(x); cur_y_in = 12'(y); cur_c0_in = c0; cur_c1_in = c1;
        if (!lk) begin e_x = x; e_y = y; e_c0 = c0; e_c1 = c1; end
        e_w = (hd + 1) * 8;
        tick(0, 0, 0, 0);
        tick(0, 0, 0, 0);
    endtask

    task automatic run_line(input int y, input int x0, input int x1);
        bit hit;
        hit = cur_en && y >= e_y && y < e_y + 64 && y <= int'(v_end);
        line_y = 12'(y);
        rd_k = 0;
        tick(1, 0, 0, 0);
        e_lhit = hit;
        e_row = y - e_y;
        repeat (20) tick(0, 0, 0, 0);
        checks++;
        if (rd_k != (hit ? 16 : 0)) begin
            fails++;
            $display("FAIL %s read count got %0d exp %0d", hit ? "R1" : "R6", rd_k, hit ? 16 : 0);
        end
        for (int x = (x0 < 0 ? 0 : x0); x <= x1; x++) begin
            if ($urandom % 6 == 0) tick(0, 0, 0, 0);
            tick(0, 1, x, $urandom);
        end
        tick(0, 0, 0, 0);
        tick(0, 0, 0, 0);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 1024; i++) bmem[i] = 8'($urandom);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || bm_rd !== 1'b0) begin
            fails++;
            $display("FAIL R9 reset state got %b%b exp 00", out_valid, bm_rd);
        end
        set_cfg(1, 0, 100, 50, 24'h123456, 24'hABCDEF, 39, 479);
        run_line(50, 96, 170);     // row 0
        run_line(113, 96, 170);    // row 63
        run_line(49, 96, 170);     // R6 above
        run_line(114, 96, 170);    // R6 below
        set_cfg(1, 0, 100, 50, 24'h123456, 24'hABCDEF, 39, 60);
        run_line(70, 96, 170);     // R6 beyond v_end
        set_cfg(0, 0, 100, 50, 24'h123456, 24'hABCDEF, 39, 479);
        run_line(60, 96, 170);     // R6 disabled
        set_cfg(1, 0, 290, 50, 24'h0F0F0F, 24'hF0F0F0, 39, 479);
        run_line(60, 286, 330);    // R7 right-edge clip
        set_cfg(1, 1, 10, 10, 24'h777777, 24'h888888, 39, 479);
        run_line(60, 0, 360);      // R8 lock holds old position/colours
        set_cfg(1, 0, 10, 10, 24'h777777, 24'h888888, 39, 479);
        run_line(60, 0, 80);
        for (int n = 0; n < 8; n++) begin
            int hx, hy, hd;
            hx = $urandom % 250; hy = $urandom % 100; hd = 15 + $urandom % 26;
            set_cfg(1, 0, hx, hy, 24'($urandom), 24'($urandom), hd, 479);
            run_line(hy + $urandom % 70, hx - 3, hx + 67);
        end
        done = 1;
        summary();
        $finish;
    end
endmodule